// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of every hardware thread in a multithreaded instruction front end. For each thread it keeps a state code, the current fetch PC with its sequential successor, a small tag for the outstanding instruction-cache miss, and four sticky stall flags. Each flag is owned by one downstream stage: decode, rename, execute or commit. The surrounding fetch logic reports what happened to a thread in the cycle: a miss was issued, the PC advanced, a trap or a quiesce point was reached, a completed miss was consumed, or a sleeping thread was woken. The controller merges these reports with squash redirects from commit and decode, the reorder-buffer-still-squashing indication, stall pulses and cache fill returns. From them it produces the next state of each thread.

All squash and stall inputs for one thread are resolved in a single cycle under a fixed priority. The priority order is: commit squash, then reorder-buffer squashing, then decode squash, then an accepted fill, then stalls, then the thread's own events. A fill only counts if the thread is still waiting on a miss and the fill carries the tag of that miss. After a squash and a new miss, a late return from the old miss is therefore dropped. The block also reports whether the fetch stage as a whole has work. It raises a one-cycle change pulse per thread whenever that thread's state register is written.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: After reset every thread is in the run state (code 0), its PC equals `reset_pc`, its next PC equals `reset_pc` plus `INST_BYTES`, its miss tag is 0, no stall flag is set and `state_chg` is low. State codes: 0 run, 1 idle, 2 squashing, 3 blocked, 4 miss-wait, 5 miss-done, 6 trap-pending, 7 quiesce-pending.
- R2: Each of the four stages has a sticky per-thread stall flag. A block pulse sets the flag and it stays set with no further pulse. An unblock pulse clears it, and an unblock is only legal while the flag is set and no block pulse arrives for the same flag.
- R3: A commit squash has the highest priority. It sets PC to the redirect target and next PC to the target plus `INST_BYTES`, enters squashing, and abandons any outstanding miss. A decode squash in the same cycle has no effect.
- R4: Without a commit squash, a reorder-buffer-squashing indication puts or keeps the thread in squashing and leaves its PC unchanged, even if a decode squash arrives in the same cycle.
- R5: A decode squash redirects the thread like a commit squash only if the thread is not already squashing. Otherwise its target is ignored and the PC is kept.
- R6: If no squash applies, a thread not in miss-wait goes to blocked when any of its stall flags (as updated this cycle) is set or `ctx_switch` is high. A thread in miss-wait stays there regardless of stalls. Otherwise a blocked or squashing thread returns to run.
- R7: A miss issue from a running thread with no higher-priority event enters miss-wait and increments the thread's 2-bit tag (wrapping), which appears on `miss_tag`.
- R8: A fill is accepted only when `fill_tid` names the thread, the thread is in miss-wait and `fill_tag` equals its current tag. An accepted fill enters blocked if any stall is active and miss-done otherwise. Other fills change nothing.
- R9: A grant moves miss-done to run. In run, an advance loads PC from `adv_pc` (next PC = `adv_pc` + `INST_BYTES`) without a state change, trap enters trap-pending and quiesce enters quiesce-pending. Wake moves quiesce-pending to run.
- R10: `stage_active` is high exactly when at least one thread is in run, squashing or miss-done.
- R11: `state_chg` for a thread is high in the cycle after one in which that thread's state register was written, including a write of the same value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reset_pc | input | PC_W | Start PC loaded into every thread at reset |
| ctx_switch | input | 1 | Global stall for all threads |
| dec_blk | input | N | Decode block pulse per thread |
| dec_unblk | input | N | Decode unblock pulse per thread |
| ren_blk | input | N | Rename block pulse per thread |
| ren_unblk | input | N | Rename unblock pulse per thread |
| exe_blk | input | N | Execute block pulse per thread |
| exe_unblk | input | N | Execute unblock pulse per thread |
| cmt_blk | input | N | Commit block pulse per thread |
| cmt_unblk | input | N | Commit unblock pulse per thread |
| cmt_squash | input | N | Commit squash per thread |
| cmt_pc | input | N*PC_W | Commit redirect targets |
| rob_squashing | input | N | Reorder buffer still squashing per thread |
| dec_squash | input | N | Decode squash per thread |
| dec_pc | input | N*PC_W | Decode redirect targets |
| miss_issue | input | N | Cache miss issued for thread |
| fill_valid | input | 1 | Cache fill return |
| fill_tid | input | TID_W | Thread of the fill |
| fill_tag | input | TAG_W | Tag of the fill |
| adv | input | N | PC advance for a running thread |
| adv_pc | input | N*PC_W | Advance targets |
| trap | input | N | Trap detected for a running thread |
| quiesce | input | N | Quiesce point for a running thread |
| grant | input | N | Miss-done thread picked for fetch |
| wake | input | N | Wake a quiesced thread |
| thread_state | output | N*3 | State code per thread |
| thread_pc | output | N*PC_W | Current PC per thread |
| thread_npc | output | N*PC_W | Next PC per thread |
| miss_tag | output | N*TAG_W | Current miss tag per thread |
| state_chg | output | N | State-write pulse per thread |
| stage_active | output | 1 | Any thread has fetch work |

## Verification
On every cycle the embedded properties check several rules. A set stall flag stays set, and an unblock arrives only when its flag is set. A commit squash always lands in squashing with the exact redirect PC and raises the change pulse. The reorder-buffer indication never moves the PC. A decode squash during squashing leaves the PC alone. A pending miss survives stalls and wrong-tag fills, and each issued miss steps the tag by one. The directed scenarios show the rest, which depend on sequences: several stage flags held at once and released in turn, the stale return after squash-and-reissue with tag wraparound, fills addressed to the other thread, the idle-stage indication when every thread is trapped, blocked or quiesced, and a PC advance that does not raise the change pulse.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    TS_RUN       = 3'd0,
    TS_IDLE      = 3'd1,
    TS_SQUASH    = 3'd2,
    TS_BLOCK     = 3'd3,
    TS_MISS_WAIT = 3'd4,
    TS_MISS_DONE = 3'd5,
    TS_TRAP      = 3'd6,
    TS_QUIESCE   = 3'd7
  } tstate_e;

  localparam int unsigned STATE_W       = 3;
  localparam int unsigned NUM_STALL_SRC = 4;

endpackage

// File: rtl/fts_rst_sync.sv
module fts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fts_stall_flags.sv
module fts_stall_flags #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] blk,
  input  logic [NSRC-1:0] unblk,
  output logic            any_stall_d
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_d;
  logic [NSRC-1:0] flag_en;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_comb begin
      flag_en[s] = blk[s] | unblk[s];
      flag_d[s]  = unblk[s] ? 1'b0 : (blk[s] ? 1'b1 : flag_q[s]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[s] <= 1'b0;
      end else if (flag_en[s]) begin
        flag_q[s] <= flag_d[s];
      end
    end

    // R2: an unblock must find its flag set and no competing block
    assert_unblock_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      unblk[s] |-> (flag_q[s] && !blk[s]));

    // R2: a block leaves the flag set afterwards
    assert_block_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      blk[s] |=> flag_q[s]);

    // R2: without pulses the flag holds
    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk[s] && !unblk[s]) |=> $stable(flag_q[s]));
  end

  assign any_stall_d = |flag_d;

endmodule

// File: rtl/fts_thread_fsm.sv
module fts_thread_fsm
  import fts_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned TAG_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  reset_pc,
  input  logic             any_stall,
  input  logic             cmt_squash,
  input  logic [PC_W-1:0]  cmt_pc,
  input  logic             rob_squashing,
  input  logic             dec_squash,
  input  logic [PC_W-1:0]  dec_pc,
  input  logic             fill_hit,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             miss_issue,
  input  logic             adv,
  input  logic [PC_W-1:0]  adv_pc,
  input  logic             trap,
  input  logic             quiesce,
  input  logic             grant,
  input  logic             wake,
  output tstate_e          state_q,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  npc_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             chg_q
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  tstate_e          state_d;
  logic [PC_W-1:0]  pc_d;
  logic [TAG_W-1:0] tag_d;
  logic             state_we;
  logic             pc_we;
  logic             tag_we;
  logic             fill_ok;
  logic             any_squash;

  assign fill_ok    = fill_hit && (state_q == TS_MISS_WAIT) && (fill_tag == tag_q);
  assign any_squash = cmt_squash || rob_squashing ||
                      (dec_squash && (state_q != TS_SQUASH));

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    tag_d    = tag_q + TAG_W'(1);
    state_we = 1'b0;
    pc_we    = 1'b0;
    tag_we   = 1'b0;
    if (cmt_squash) begin
      state_d  = TS_SQUASH;
      state_we = 1'b1;
      pc_d     = cmt_pc;
      pc_we    = 1'b1;
    end else if (rob_squashing) begin
      state_d  = TS_SQUASH;
      state_we = 1'b1;
    end else if (dec_squash && (state_q != TS_SQUASH)) begin
      state_d  = TS_SQUASH;
      state_we = 1'b1;
      pc_d     = dec_pc;
      pc_we    = 1'b1;
    end else if (fill_ok) begin
      state_d  = any_stall ? TS_BLOCK : TS_MISS_DONE;
      state_we = 1'b1;
    end else if ((state_q != TS_MISS_WAIT) && any_stall) begin
      state_d  = TS_BLOCK;
      state_we = 1'b1;
    end else if ((state_q == TS_BLOCK) || (state_q == TS_SQUASH)) begin
      state_d  = TS_RUN;
      state_we = 1'b1;
    end else begin
      unique case (state_q)
        TS_RUN: begin
          if (miss_issue) begin
            state_d  = TS_MISS_WAIT;
            state_we = 1'b1;
            tag_we   = 1'b1;
          end else begin
            if (adv) begin
              pc_d  = adv_pc;
              pc_we = 1'b1;
            end
            if (trap) begin
              state_d  = TS_TRAP;
              state_we = 1'b1;
            end else if (quiesce) begin
              state_d  = TS_QUIESCE;
              state_we = 1'b1;
            end
          end
        end
        TS_MISS_DONE: begin
          if (grant) begin
            state_d  = TS_RUN;
            state_we = 1'b1;
          end
        end
        TS_QUIESCE: begin
          if (wake) begin
            state_d  = TS_RUN;
            state_we = 1'b1;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_RUN;
      pc_q    <= reset_pc;
      npc_q   <= reset_pc + STEP;
      tag_q   <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= state_we;
      if (state_we) begin
        state_q <= state_d;
      end
      if (pc_we) begin
        pc_q  <= pc_d;
        npc_q <= pc_d + STEP;
      end
      if (tag_we) begin
        tag_q <= tag_d;
      end
    end
  end

  // R3: commit squash lands in squashing with the redirect PC
  assert_cmt_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (state_q == TS_SQUASH) && (pc_q == $past(cmt_pc)) &&
                   (npc_q == $past(cmt_pc) + STEP));

  // R4: reorder-buffer squashing keeps squashing and never moves the PC
  assert_rob_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && rob_squashing) |=> (state_q == TS_SQUASH) && $stable(pc_q));

  // R5: decode squash while squashing leaves the PC alone
  assert_dec_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && !rob_squashing && dec_squash && (state_q == TS_SQUASH))
      |=> $stable(pc_q));

  // R6: a pending miss is not moved by stalls
  assert_miss_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_MISS_WAIT) && !any_squash && !fill_hit) |=> (state_q == TS_MISS_WAIT));

  // R8: a fill with the wrong tag leaves the miss pending
  assert_stale_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_MISS_WAIT) && !any_squash && fill_hit && (fill_tag != tag_q))
      |=> (state_q == TS_MISS_WAIT));

  // R7: each issued miss steps the tag by one
  assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_RUN) && !any_squash && !any_stall && miss_issue)
      |=> (state_q == TS_MISS_WAIT) && (tag_q == $past(tag_q) + TAG_W'(1)));

  // R11: a commit squash always raises the change pulse
  assert_chg_on_squash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> chg_q);

endmodule

// File: rtl/fts_activity.sv
module fts_activity
  import fts_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic [N*STATE_W-1:0] states,
  output logic                 active
);

  logic [N-1:0] busy;

  for (genvar t = 0; t < N; t++) begin : g_thr
    logic [STATE_W-1:0] s;
    assign s = states[t*STATE_W +: STATE_W];
    assign busy[t] = (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_MISS_DONE);
  end

  assign active = |busy;

endmodule

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl
  import fts_pkg::*;
#(
  parameter int unsigned N          = 2,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned TAG_W      = 2,
  localparam int unsigned TID_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      reset_pc,
  input  logic                 ctx_switch,
  input  logic [N-1:0]         dec_blk,
  input  logic [N-1:0]         dec_unblk,
  input  logic [N-1:0]         ren_blk,
  input  logic [N-1:0]         ren_unblk,
  input  logic [N-1:0]         exe_blk,
  input  logic [N-1:0]         exe_unblk,
  input  logic [N-1:0]         cmt_blk,
  input  logic [N-1:0]         cmt_unblk,
  input  logic [N-1:0]         cmt_squash,
  input  logic [N*PC_W-1:0]    cmt_pc,
  input  logic [N-1:0]         rob_squashing,
  input  logic [N-1:0]         dec_squash,
  input  logic [N*PC_W-1:0]    dec_pc,
  input  logic [N-1:0]         miss_issue,
  input  logic                 fill_valid,
  input  logic [TID_W-1:0]     fill_tid,
  input  logic [TAG_W-1:0]     fill_tag,
  input  logic [N-1:0]         adv,
  input  logic [N*PC_W-1:0]    adv_pc,
  input  logic [N-1:0]         trap,
  input  logic [N-1:0]         quiesce,
  input  logic [N-1:0]         grant,
  input  logic [N-1:0]         wake,
  output logic [N*STATE_W-1:0] thread_state,
  output logic [N*PC_W-1:0]    thread_pc,
  output logic [N*PC_W-1:0]    thread_npc,
  output logic [N*TAG_W-1:0]   miss_tag,
  output logic [N-1:0]         state_chg,
  output logic                 stage_active
);

  logic rst_n_int;

  fts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar t = 0; t < N; t++) begin : g_thread
    logic    stall_flags;
    logic    fill_hit;
    tstate_e st;

    fts_stall_flags #(.NSRC(NUM_STALL_SRC)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .blk         ({cmt_blk[t], exe_blk[t], ren_blk[t], dec_blk[t]}),
      .unblk       ({cmt_unblk[t], exe_unblk[t], ren_unblk[t], dec_unblk[t]}),
      .any_stall_d (stall_flags)
    );

    assign fill_hit = fill_valid && (fill_tid == TID_W'(t));

    fts_thread_fsm #(
      .PC_W       (PC_W),
      .INST_BYTES (INST_BYTES),
      .TAG_W      (TAG_W)
    ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n_int),
      .reset_pc      (reset_pc),
      .any_stall     (stall_flags | ctx_switch),
      .cmt_squash    (cmt_squash[t]),
      .cmt_pc        (cmt_pc[t*PC_W +: PC_W]),
      .rob_squashing (rob_squashing[t]),
      .dec_squash    (dec_squash[t]),
      .dec_pc        (dec_pc[t*PC_W +: PC_W]),
      .fill_hit      (fill_hit),
      .fill_tag      (fill_tag),
      .miss_issue    (miss_issue[t]),
      .adv           (adv[t]),
      .adv_pc        (adv_pc[t*PC_W +: PC_W]),
      .trap          (trap[t]),
      .quiesce       (quiesce[t]),
      .grant         (grant[t]),
      .wake          (wake[t]),
      .state_q       (st),
      .pc_q          (thread_pc[t*PC_W +: PC_W]),
      .npc_q         (thread_npc[t*PC_W +: PC_W]),
      .tag_q         (miss_tag[t*TAG_W +: TAG_W]),
      .chg_q         (state_chg[t])
    );

    assign thread_state[t*STATE_W +: STATE_W] = st;
  end

  fts_activity #(.N(N)) u_act (
    .states (thread_state),
    .active (stage_active)
  );

  // R10: after any commit squash the stage has work
  assert_active_after_squash_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|cmt_squash) |=> stage_active);

endmodule

// File: tb/fetch_thread_ctrl_tb.sv
module fetch_thread_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 2;
  localparam int PC_W = 32;
  localparam int TW   = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [PC_W-1:0]   reset_pc;
  logic              ctx_switch;
  logic [N-1:0]      dec_blk, dec_unblk, ren_blk, ren_unblk;
  logic [N-1:0]      exe_blk, exe_unblk, cmt_blk, cmt_unblk;
  logic [N-1:0]      cmt_squash, rob_squashing, dec_squash;
  logic [N*PC_W-1:0] cmt_pc, dec_pc, adv_pc;
  logic [N-1:0]      miss_issue, adv, trap, quiesce, grant, wake;
  logic              fill_valid;
  logic [0:0]        fill_tid;
  logic [TW-1:0]     fill_tag;
  logic [N*3-1:0]    thread_state;
  logic [N*PC_W-1:0] thread_pc, thread_npc;
  logic [N*TW-1:0]   miss_tag;
  logic [N-1:0]      state_chg;
  logic              stage_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_thread_ctrl #(.N(N), .PC_W(PC_W), .INST_BYTES(4), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc), .ctx_switch(ctx_switch),
    .dec_blk(dec_blk), .dec_unblk(dec_unblk), .ren_blk(ren_blk), .ren_unblk(ren_unblk),
    .exe_blk(exe_blk), .exe_unblk(exe_unblk), .cmt_blk(cmt_blk), .cmt_unblk(cmt_unblk),
    .cmt_squash(cmt_squash), .cmt_pc(cmt_pc), .rob_squashing(rob_squashing),
    .dec_squash(dec_squash), .dec_pc(dec_pc), .miss_issue(miss_issue),
    .fill_valid(fill_valid), .fill_tid(fill_tid), .fill_tag(fill_tag),
    .adv(adv), .adv_pc(adv_pc), .trap(trap), .quiesce(quiesce), .grant(grant),
    .wake(wake), .thread_state(thread_state), .thread_pc(thread_pc),
    .thread_npc(thread_npc), .miss_tag(miss_tag), .state_chg(state_chg),
    .stage_active(stage_active)
  );

  localparam logic [2:0] S_RUN = 3'd0, S_SQ = 3'd2, S_BLK = 3'd3, S_MW = 3'd4,
                         S_MD = 3'd5, S_TRAP = 3'd6, S_QUI = 3'd7;

  function automatic logic [2:0] st(int t);
    return thread_state[t*3 +: 3];
  endfunction
  function automatic logic [31:0] pc(int t);
    return thread_pc[t*PC_W +: PC_W];
  endfunction
  function automatic logic [31:0] npc(int t);
    return thread_npc[t*PC_W +: PC_W];
  endfunction
  function automatic logic [31:0] tg(int t);
    return 32'(miss_tag[t*TW +: TW]);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    ctx_switch = 0; dec_blk = 0; dec_unblk = 0; ren_blk = 0; ren_unblk = 0;
    exe_blk = 0; exe_unblk = 0; cmt_blk = 0; cmt_unblk = 0;
    cmt_squash = 0; rob_squashing = 0; dec_squash = 0;
    cmt_pc = '0; dec_pc = '0; adv_pc = '0;
    miss_issue = 0; adv = 0; trap = 0; quiesce = 0; grant = 0; wake = 0;
    fill_valid = 0; fill_tid = 0; fill_tag = 0;
  endtask

  // advance one clock, sample 1 time unit after the edge, then clear pulses
  task automatic step();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic t_reset();
    chk("R1", "state0", 32'(st(0)), 32'(S_RUN));
    chk("R1", "state1", 32'(st(1)), 32'(S_RUN));
    chk("R1", "pc0", pc(0), 32'h1000);
    chk("R1", "npc1", npc(1), 32'h1004);
    chk("R1", "tag0", tg(0), 0);
    chk("R1", "chg", 32'(state_chg), 0);
    chk("R10", "active at reset", 32'(stage_active), 1);
    step();
    chk("R1", "no stall after reset", 32'(st(0)), 32'(S_RUN));
  endtask

  task automatic t_stall();
    dec_blk[0] = 1; step();
    chk("R2", "decode block", 32'(st(0)), 32'(S_BLK));
    chk("R2", "other thread", 32'(st(1)), 32'(S_RUN));
    chk("R11", "chg on block", 32'(state_chg[0]), 1);
    step();
    chk("R2", "flag sticky", 32'(st(0)), 32'(S_BLK));
    ren_blk[0] = 1; exe_blk[0] = 1; step();
    dec_unblk[0] = 1; step();
    chk("R2", "others still set", 32'(st(0)), 32'(S_BLK));
    ren_unblk[0] = 1; step();
    chk("R2", "execute still set", 32'(st(0)), 32'(S_BLK));
    exe_unblk[0] = 1; step();
    chk("R6", "all clear to run", 32'(st(0)), 32'(S_RUN));
    step();
    chk("R11", "chg idle low", 32'(state_chg[0]), 0);
  endtask

  task automatic t_ctx();
    ctx_switch = 1; step();
    chk("R6", "ctx blocks t0", 32'(st(0)), 32'(S_BLK));
    chk("R6", "ctx blocks t1", 32'(st(1)), 32'(S_BLK));
    chk("R10", "inactive when all blocked", 32'(stage_active), 0);
    step();
    chk("R6", "release ctx", 32'(st(1)), 32'(S_RUN));
  endtask

  task automatic t_cmt();
    cmt_squash[1] = 1; cmt_pc[63:32] = 32'h2000;
    dec_squash[1] = 1; dec_pc[63:32] = 32'h3000;
    step();
    chk("R3", "squash state", 32'(st(1)), 32'(S_SQ));
    chk("R3", "pc", pc(1), 32'h2000);
    chk("R3", "npc", npc(1), 32'h2004);
    step();
    chk("R6", "squash to run", 32'(st(1)), 32'(S_RUN));
  endtask

  task automatic t_dec();
    dec_squash[0] = 1; dec_pc[31:0] = 32'h4000; step();
    chk("R5", "decode redirect", pc(0), 32'h4000);
    chk("R5", "decode state", 32'(st(0)), 32'(S_SQ));
    dec_squash[0] = 1; dec_pc[31:0] = 32'h5000; step();
    chk("R5", "ignored while squashing", pc(0), 32'h4000);
    chk("R6", "falls through to run", 32'(st(0)), 32'(S_RUN));
  endtask

  task automatic t_rob();
    rob_squashing[0] = 1; dec_squash[0] = 1; dec_pc[31:0] = 32'h6000; step();
    chk("R4", "rob squash state", 32'(st(0)), 32'(S_SQ));
    chk("R4", "pc kept", pc(0), 32'h4000);
    rob_squashing[0] = 1; step();
    chk("R4", "rob hold", 32'(st(0)), 32'(S_SQ));
    chk("R11", "same value write pulses", 32'(state_chg[0]), 1);
    step();
    chk("R6", "rob release", 32'(st(0)), 32'(S_RUN));
  endtask

  task automatic t_miss();
    miss_issue[0] = 1; step();
    chk("R7", "miss wait", 32'(st(0)), 32'(S_MW));
    chk("R7", "tag 1", tg(0), 1);
    dec_blk[0] = 1; step();
    chk("R6", "stall ignored in miss", 32'(st(0)), 32'(S_MW));
    fill_valid = 1; fill_tid = 0; fill_tag = 2; step();
    chk("R8", "wrong tag dropped", 32'(st(0)), 32'(S_MW));
    fill_valid = 1; fill_tid = 1; fill_tag = 1; step();
    chk("R8", "other tid t0", 32'(st(0)), 32'(S_MW));
    chk("R8", "other tid t1", 32'(st(1)), 32'(S_RUN));
    fill_valid = 1; fill_tid = 0; fill_tag = 1; step();
    chk("R8", "fill with stall", 32'(st(0)), 32'(S_BLK));
    dec_unblk[0] = 1; step();
    chk("R6", "unblock", 32'(st(0)), 32'(S_RUN));
    miss_issue[0] = 1; step();
    chk("R7", "tag 2", tg(0), 2);
    fill_valid = 1; fill_tid = 0; fill_tag = 2; step();
    chk("R8", "fill done", 32'(st(0)), 32'(S_MD));
    grant[0] = 1; step();
    chk("R9", "grant to run", 32'(st(0)), 32'(S_RUN));
  endtask

  task automatic t_stale();
    miss_issue[0] = 1; step();
    chk("R7", "tag 3", tg(0), 3);
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h7000; step();
    chk("R3", "squash drops miss", 32'(st(0)), 32'(S_SQ));
    step();
    miss_issue[0] = 1; step();
    chk("R7", "tag wraps", tg(0), 0);
    fill_valid = 1; fill_tid = 0; fill_tag = 3; step();
    chk("R8", "stale fill dropped", 32'(st(0)), 32'(S_MW));
    fill_valid = 1; fill_tid = 0; fill_tag = 0; step();
    chk("R8", "fresh fill", 32'(st(0)), 32'(S_MD));
    chk("R10", "active in miss-done", 32'(stage_active), 1);
    grant[0] = 1; step();
  endtask

  task automatic t_events();
    adv[0] = 1; adv_pc[31:0] = 32'h7010; step();
    chk("R9", "advance pc", pc(0), 32'h7010);
    chk("R9", "advance npc", npc(0), 32'h7014);
    chk("R11", "advance no pulse", 32'(state_chg[0]), 0);
    trap[0] = 1; step();
    chk("R9", "trap", 32'(st(0)), 32'(S_TRAP));
    chk("R10", "t1 keeps active", 32'(stage_active), 1);
    quiesce[1] = 1; step();
    chk("R9", "quiesce", 32'(st(1)), 32'(S_QUI));
    chk("R10", "inactive", 32'(stage_active), 0);
    wake[1] = 1; step();
    chk("R9", "wake", 32'(st(1)), 32'(S_RUN));
    cmt_squash[0] = 1; cmt_pc[31:0] = 32'h8000; step();
    chk("R3", "trap exits by squash", 32'(st(0)), 32'(S_SQ));
    chk("R3", "trap redirect pc", pc(0), 32'h8000);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    clear_in();
    reset_pc = 32'h1000;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_stall();
    t_ctx();
    t_cmt();
    t_dec();
    t_rob();
    t_miss();
    t_stale();
    t_events();
    done = 1;
    finish_run();
  end

endmodule